// File: doc/BRIEF.md
# Six-Channel DMA Request Priority Arbiter

This block decides which of six DMA channels in one group may use the transfer engine next. Each channel raises a request line. When no channel holds the grant, the arbiter picks one requester in a single clock and holds that one-hot grant until the engine pulses a transfer-done strobe. It then releases the grant, and arbitration runs again from the following cycle.

A 2-bit order field selects the rule used at each decision. There are two fixed orders and one rotating order, and the last of these moves its starting point after every completed transfer. A group enable and a group error flag gate the whole block. If the enable is low or the error flag is high, no grant is visible, and any held grant is dropped at the next clock.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `grant` is all zero, `grant_vld` is low and the rotation pointer is channel 0.
- R2: With `order_sel` = 2'b00, the requesting channel with the lowest index wins.
- R3: With `order_sel` = 2'b01, the winner follows the rank ch0, ch2, ch3, ch1, ch4, ch5 (first listed wins). Channel 1 therefore loses to channels 2 and 3.
- R4: The value `order_sel` = 2'b10 is not meant to be used. If it is set anyway, the block arbitrates exactly as for 2'b00.
- R5: With `order_sel` = 2'b11, the search for a winner starts at the rotation pointer and moves upward, wrapping after channel 5 to channel 0. Every completed grant, in any mode, sets the pointer to the granted index plus one, with channel 5 wrapping to 0.
- R6: `grant` is one-hot or all zero. `grant_vld` is high exactly when `grant` is non-zero.
- R7: When no grant is held, the gate is open and at least one request is high, a grant to a requesting channel appears after the next rising clock edge.
- R8: A grant stays unchanged until `xfer_done` is seen with the grant present, whatever `req` and `order_sel` do in the meantime. The grant is gone after that edge. A new order takes effect only at the next decision.
- R9: While `grp_en` is low, `grant` and `grant_vld` are zero in the same cycle. A held grant is dropped, and no new decision is made.
- R10: While `addr_err` is high, `grant` and `grant_vld` are zero even with `grp_en` high. A held grant is dropped, and no new decision is made.
- R11: A `xfer_done` pulse while no grant is held has no effect, and the rotation pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 6 | Per-channel request lines |
| order_sel | input | 2 | Order rule: 00 ascending, 01 channel 1 demoted, 10 reserved, 11 rotating |
| grp_en | input | 1 | Group enable |
| addr_err | input | 1 | Group address-error flag; blocks all grants |
| xfer_done | input | 1 | One-cycle strobe that ends the current grant |
| grant | output | 6 | One-hot grant to the winning channel |
| grant_vld | output | 1 | A grant is present |

## Verification
The bound checker watches several properties on every cycle. It checks that the grant is one-hot, that the valid flag matches it, and that the gate forces both to zero. It checks that a held grant stays stable until done and that done clears it. It also checks that an idle, open arbiter with requests grants one of the channels that requested. Only the directed scenarios can show which channel wins under each order rule. They also show how the rotation pointer moves and wraps, that the reserved encoding matches ascending order, that a mode change is deferred, and that a stray done leaves the pointer alone.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH       = 6,
  parameter int DEMOTE_CH = 1,
  parameter int DEMOTE_BY = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [1:0]     order_sel,
  input  logic           grp_en,
  input  logic           addr_err,
  input  logic           xfer_done,
  output logic [NCH-1:0] grant,
  output logic           grant_vld
);
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] grant_q;
  logic [NCH-1:0] pick;
  logic [PW-1:0]  ptr;
  logic [PW-1:0]  gidx;
  logic [PW-1:0]  ptr_nxt;
  logic           open_gate;
  logic           rr_mode;
  logic           alt_mode;

  assign open_gate = grp_en & ~addr_err;
  assign rr_mode   = (order_sel == 2'b11);
  assign alt_mode  = (order_sel == 2'b01);
  assign grant     = open_gate ? grant_q : '0;
  assign grant_vld = |grant;

  function automatic logic [PW-1:0] rank_to_ch(input logic alt, input int k);
    int c;
    c = k;
    if (alt) begin
      if (k >= DEMOTE_CH && k < DEMOTE_CH + DEMOTE_BY) c = k + 1;
      else if (k == DEMOTE_CH + DEMOTE_BY)              c = DEMOTE_CH;
    end
    return PW'(c);
  endfunction

  always_comb begin
    logic          found;
    logic [PW:0]   sum;
    logic [PW-1:0] c;
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      sum = {1'b0, ptr} + (PW+1)'(k);
      if (sum >= (PW+1)'(NCH)) sum = sum - (PW+1)'(NCH);
      c = rr_mode ? sum[PW-1:0] : rank_to_ch(alt_mode, k);
      if (!found && req[c]) begin
        pick[c] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_q[i]) gidx = PW'(i);
  end

  assign ptr_nxt = (gidx == PW'(NCH-1)) ? '0 : gidx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      ptr     <= '0;
    end else if (!open_gate) begin
      grant_q <= '0;
    end else if (grant_q != '0) begin
      if (xfer_done) begin
        grant_q <= '0;
        ptr     <= ptr_nxt;
      end
    end else begin
      grant_q <= pick;
    end
  end
endmodule

module dma_prio_arb_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic           grp_en,
  input logic           addr_err,
  input logic           xfer_done,
  input logic [NCH-1:0] grant,
  input logic           grant_vld
);
  logic gate_ok;
  assign gate_ok = grp_en & ~addr_err;

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r6_vld_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (grant != '0));

  a_r9_en_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_en |-> (grant == '0 && !grant_vld));

  a_r10_err_gate: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (grant == '0 && !grant_vld));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !xfer_done) |=> (grant == $past(grant)) || !gate_ok);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && xfer_done) |=> !grant_vld);

  a_r7_decide: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ok && !grant_vld && req != '0) |=> ((grant & $past(req)) != '0) || !gate_ok);
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grp_en(grp_en), .addr_err(addr_err),
  .xfer_done(xfer_done), .grant(grant), .grant_vld(grant_vld)
);

// File: tb/dma_prio_arb_tb.sv
`timescale 1ns/1ps
module dma_prio_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req = '0;
  logic [1:0] order_sel = 2'b00;
  logic       grp_en = 1'b1;
  logic       addr_err = 1'b0;
  logic       xfer_done = 1'b0;
  logic [5:0] grant;
  logic       grant_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_prio_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .order_sel(order_sel), .grp_en(grp_en),
    .addr_err(addr_err), .xfer_done(xfer_done), .grant(grant), .grant_vld(grant_vld)
  );

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; order_sel = 2'b00; grp_en = 1'b1; addr_err = 1'b0; xfer_done = 1'b0;
    step();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic decide(input logic [1:0] m, input logic [5:0] r);
    order_sel = m; req = r;
    step();
  endtask

  task automatic finish_xfer();
    req = '0; xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 grant after reset", grant, 6'b0);
    chk("R1 vld after reset", {5'b0, grant_vld}, 6'b0);
    decide(2'b11, 6'b111111);
    chk("R1 pointer starts at ch0", grant, 6'b000001);
    finish_xfer();
  endtask

  task automatic t_ascending();
    do_reset();
    decide(2'b00, 6'b111111);
    chk("R2 all request", grant, 6'b000001);
    chk("R6 vld with grant", {5'b0, grant_vld}, 6'b1);
    finish_xfer();
    chk("R8 released after done", grant, 6'b0);
    decide(2'b00, 6'b101100);
    chk("R2 lowest of 2,3,5", grant, 6'b000100);
    finish_xfer();
    decide(2'b00, 6'b100000);
    chk("R7 single requester ch5", grant, 6'b100000);
    finish_xfer();
  endtask

  task automatic t_demoted();
    do_reset();
    decide(2'b01, 6'b000110);
    chk("R3 ch2 beats ch1", grant, 6'b000100);
    finish_xfer();
    decide(2'b01, 6'b001010);
    chk("R3 ch3 beats ch1", grant, 6'b001000);
    finish_xfer();
    decide(2'b01, 6'b010010);
    chk("R3 ch1 beats ch4", grant, 6'b000010);
    finish_xfer();
    decide(2'b01, 6'b001011);
    chk("R3 ch0 first", grant, 6'b000001);
    finish_xfer();
  endtask

  task automatic t_reserved();
    do_reset();
    decide(2'b10, 6'b000110);
    chk("R4 reserved acts ascending", grant, 6'b000010);
    finish_xfer();
  endtask

  task automatic t_rotate();
    do_reset();
    decide(2'b11, 6'b111111);
    chk("R5 rr first ch0", grant, 6'b000001);
    finish_xfer();
    decide(2'b11, 6'b111111);
    chk("R5 rr next ch1", grant, 6'b000010);
    finish_xfer();
    decide(2'b11, 6'b100001);
    chk("R5 search from ch2 finds ch5", grant, 6'b100000);
    finish_xfer();
    decide(2'b11, 6'b100001);
    chk("R5 wrap to ch0", grant, 6'b000001);
    finish_xfer();
  endtask

  task automatic t_hold();
    do_reset();
    decide(2'b00, 6'b000011);
    chk("R8 first grant ch0", grant, 6'b000001);
    order_sel = 2'b01; req = 6'b000110;
    step(); step();
    chk("R8 held across mode and req change", grant, 6'b000001);
    finish_xfer();
    decide(2'b01, 6'b000110);
    chk("R8 new mode at next decision", grant, 6'b000100);
    finish_xfer();
  endtask

  task automatic t_enable();
    do_reset();
    decide(2'b00, 6'b001000);
    grp_en = 1'b0;
    #1;
    chk("R9 grant hidden same cycle", grant, 6'b0);
    chk("R9 vld low same cycle", {5'b0, grant_vld}, 6'b0);
    req = 6'b000100;
    step(); step();
    chk("R9 no decision while disabled", grant, 6'b0);
    grp_en = 1'b1;
    step();
    chk("R9 re-enabled decides fresh", grant, 6'b000100);
    finish_xfer();
  endtask

  task automatic t_error();
    do_reset();
    decide(2'b00, 6'b010000);
    addr_err = 1'b1;
    #1;
    chk("R10 grant hidden on error", grant, 6'b0);
    req = 6'b000001;
    step(); step();
    chk("R10 no decision on error", {5'b0, grant_vld}, 6'b0);
    addr_err = 1'b0;
    #1;
    chk("R10 held grant was dropped", grant, 6'b0);
    step();
    chk("R10 decides after clear", grant, 6'b000001);
    finish_xfer();
  endtask

  task automatic t_stray_done();
    do_reset();
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk("R11 stray done no grant", grant, 6'b0);
    decide(2'b11, 6'b000011);
    chk("R11 pointer unchanged", grant, 6'b000001);
    finish_xfer();
  endtask

  initial begin
    t_reset();
    t_ascending();
    t_demoted();
    t_reserved();
    t_rotate();
    t_hold();
    t_enable();
    t_error();
    t_stray_done();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule